// File: doc/BRIEF.md
# Quadratic Permutation Address Generator

This block produces the read (or write) address sequence of a turbo-code internal interleaver whose permutation is the quadratic polynomial P(i) = (f1·i + f2·i²) mod k, for block sizes k up to 6144. It has no multiplier. Two registers hold the address P and its first difference Q, and each advances by one modular addition per step. Every modular addition is a single compare against k followed by an optional subtraction.

Software works out alpha = (f1+f2) mod k and beta = (2·f2) mod k beforehand. It loads them together with k, then pulses start. The block then emits one address per accepted cycle, together with a valid strobe and markers for the first and last index of the block. The consumer throttles the sequence with a ready input. Because P and Q both return to their starting values after k steps, back-to-back blocks with the same parameters need no reload. External memory does the actual data reordering: write in natural order and read through these addresses, or the reverse.

The controller has two states. IDLE holds the output invalid and accepts parameter loads. RUN presents addresses. The transitions are:
- IDLE→RUN (`launch`) on start.
- RUN→RUN (`chain`) when the last index is accepted while start is high.
- RUN→IDLE (`finish`) when the last index is accepted while start is low.
- RUN→RUN (`step` or `hold`) on any other cycle.

Top module: `qpp_addr_gen`

## Requirements
- R1: After reset, `valid_o` is 0 and the block is in IDLE.
- R2: A `load` pulse in IDLE captures `k_in`, `alpha_in` and `beta_in` for later runs. A `load` pulse while running is ignored, so the next run still uses the earlier values.
- R3: A `start` in IDLE makes `valid_o` 1 on the next cycle, with `addr_o` = 0 and `first_o` = 1. A `start` while running has no effect, except when it is used for R8.
- R4: On successive accepted cycles (`valid_o` and `ready` both 1), `addr_o` takes the values (f1·i + f2·i²) mod k for i = 0, 1, …, k−1, one per accepted cycle.
- R5: While `valid_o` is 1, `addr_o` is always below k.
- R6: While `valid_o` is 1 and `ready` is 0, `addr_o`, `first_o`, `last_o` and `valid_o` hold their values and the sequence does not advance.
- R7: `first_o` is 1 exactly at index 0 and `last_o` is 1 exactly at index k−1.
- R8: If `start` is 1 when index k−1 is accepted, the next cycle presents index 0 of a new block with the same sequence, and no reload takes place. If `start` is 0 at that point, `valid_o` is 0 on the next cycle.
- R9: With k = 1, every emitted address is 0, and `first_o` and `last_o` are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Capture the parameters (IDLE only) |
| k_in | input | 13 | Block size k, from 1 to 6144 |
| alpha_in | input | 13 | (f1+f2) mod k |
| beta_in | input | 13 | (2·f2) mod k |
| start | input | 1 | Begin a run, or chain a new block at the last index |
| ready | input | 1 | Consumer accepts the current address |
| addr_o | output | 13 | Interleaved address P(i) |
| valid_o | output | 1 | Address is valid |
| first_o | output | 1 | Current address is index 0 |
| last_o | output | 1 | Current address is index k−1 |

## Verification
The hardest situation to reach is the wrap at the end of a block. The only proof that P and Q really return to 0 and alpha is a second block that follows the first with no intervening start from IDLE. The stimulus holds `start` high during the final accepted cycle, so the block chains, and then checks every address of the second block against the closed-form polynomial. A second hard case is a parameter load that arrives mid-run. It is driven between addresses of a running block, and the run that follows is compared against the old parameters. A full 6144-entry block exercises the reductions at their widest values.

// File: rtl/qpp_pkg.sv
package qpp_pkg;
    localparam int unsigned ADDR_W = 13;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } qpp_state_e;
endpackage

// File: rtl/qpp_modadd.sv
module qpp_modadd #(
    parameter int unsigned W = 13
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] m,
    output logic [W-1:0] sum
);
    localparam int unsigned SW = W + 1;
    logic [SW-1:0] raw;
    logic [SW-1:0] red;

    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        red = raw - {1'b0, m};
        sum = (raw >= {1'b0, m}) ? red[W-1:0] : raw[W-1:0];
    end
endmodule

// File: rtl/qpp_index_ctr.sv
module qpp_index_ctr #(
    parameter int unsigned W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] last_idx,
    output logic         at_first,
    output logic         at_last
);
    logic [W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clr) begin
            idx_q <= '0;
        end else if (adv) begin
            idx_q <= (idx_q == last_idx) ? '0 : idx_q + 1'b1;
        end
    end

    assign at_first = (idx_q == '0);
    assign at_last  = (idx_q == last_idx);

    // R7: index never runs past the last position
    assert_idx_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= last_idx || $past(clr) == 1'b0 && $past(adv) == 1'b0);
endmodule

// File: rtl/qpp_addr_gen.sv
module qpp_addr_gen
    import qpp_pkg::*;
#(
    parameter int unsigned W = ADDR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] k_in,
    input  logic [W-1:0] alpha_in,
    input  logic [W-1:0] beta_in,
    input  logic         start,
    input  logic         ready,
    output logic [W-1:0] addr_o,
    output logic         valid_o,
    output logic         first_o,
    output logic         last_o
);
    qpp_state_e   state_q, state_d;
    logic [W-1:0] k_q, alpha_q, beta_q;
    logic [W-1:0] p_q, q_q, p_nxt, q_nxt;
    logic [W-1:0] last_idx;
    logic         launch, accept, at_first, at_last;

    assign last_idx = k_q - 1'b1;
    assign launch   = (state_q == ST_IDLE) && start;
    assign accept   = (state_q == ST_RUN) && ready;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (accept && at_last && !start) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        valid_o = 1'b0;
        first_o = 1'b0;
        last_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                valid_o = 1'b1;
                first_o = at_first;
                last_o  = at_last;
            end
            default: ;
        endcase
    end
    assign addr_o = p_q;

    // Parameter capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q     <= W'(1);
            alpha_q <= '0;
            beta_q  <= '0;
        end else if (load && state_q == ST_IDLE) begin
            k_q     <= k_in;
            alpha_q <= alpha_in;
            beta_q  <= beta_in;
        end
    end

    qpp_modadd #(.W(W)) u_add_p (.a(p_q), .b(q_q),    .m(k_q), .sum(p_nxt));
    qpp_modadd #(.W(W)) u_add_q (.a(q_q), .b(beta_q), .m(k_q), .sum(q_nxt));

    // Recurrence registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
            q_q <= '0;
        end else if (launch) begin
            p_q <= '0;
            q_q <= alpha_q;
        end else if (accept) begin
            p_q <= p_nxt;
            q_q <= q_nxt;
        end
    end

    qpp_index_ctr #(.W(W)) u_idx (
        .clk(clk), .rst_n(rst_n), .clr(launch), .adv(accept),
        .last_idx(last_idx), .at_first(at_first), .at_last(at_last)
    );

    assert_addr_below_k_R5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> addr_o < k_q);

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready) |=> (valid_o && $stable(addr_o) && $stable(first_o) && $stable(last_o)));

    assert_first_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && first_o) |-> addr_o == '0);

    assert_launch_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> first_o);

    assert_chain_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready && last_o && start) |=> (valid_o && first_o && addr_o == '0));

    assert_finish_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready && last_o && !start) |=> !valid_o);
endmodule

// File: tb/qpp_addr_gen_tb.sv
module qpp_addr_gen_tb;
    localparam int W = 13;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load = 1'b0, start = 1'b0, ready = 1'b0;
    logic [W-1:0] k_in = '0, alpha_in = '0, beta_in = '0;
    logic [W-1:0] addr_o;
    logic valid_o, first_o, last_o;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    qpp_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .load(load), .k_in(k_in), .alpha_in(alpha_in),
        .beta_in(beta_in), .start(start), .ready(ready), .addr_o(addr_o),
        .valid_o(valid_o), .first_o(first_o), .last_o(last_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint qpp(input longint f1, input longint f2, input longint k, input longint i);
        return (f1 * i + f2 * i * i) % k;
    endfunction

    task automatic do_load(input int k, input int f1, input int f2);
        @(negedge clk);
        k_in = W'(k); alpha_in = W'((f1 + f2) % k); beta_in = W'((2 * f2) % k);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic do_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Stream one block; caller is at a negedge with RUN active.
    // stall_at >= 0 inserts a 3-cycle stall; mid_load pulses load with junk.
    task automatic stream(input string tag, input int k, input int f1, input int f2,
                          input bit chain, input int stall_at, input bit mid_load);
        for (int i = 0; i < k; i++) begin
            if (i == stall_at) begin
                ready = 1'b0;
                for (int s = 0; s < 3; s++) begin
                    @(negedge clk);
                    chk({tag, " R6 addr hold"}, addr_o, qpp(f1, f2, k, i));
                    chk({tag, " R6 valid hold"}, valid_o, 1);
                end
            end
            if (mid_load && i == 2) begin
                k_in = 13'd8; alpha_in = 13'd3; beta_in = 13'd5; load = 1'b1;
            end
            ready = 1'b1;
            chk({tag, " R4 addr"}, addr_o, qpp(f1, f2, k, i));
            chk({tag, " R5 valid"}, valid_o, 1);
            chk({tag, " R7 first"}, first_o, (i == 0));
            chk({tag, " R7 last"}, last_o, (i == k - 1));
            if (i == k - 1) start = chain;
            @(negedge clk);
            load = 1'b0;
            start = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk("R1 valid after reset", valid_o, 0);
        chk("R1 first after reset", first_o, 0);
    endtask

    task automatic t_basic();
        do_load(40, 3, 10);
        do_start();
        chk("R3 first addr zero", addr_o, 0);
        chk("R3 first flag", first_o, 1);
        stream("basic", 40, 3, 10, 1'b0, -1, 1'b0);
        chk("R8 idle after finish", valid_o, 0);
    endtask

    task automatic t_stall_load();
        do_start();
        stream("stall", 40, 3, 10, 1'b0, 7, 1'b1);
        chk("R8 idle after stall block", valid_o, 0);
        do_start();
        stream("R2 old params", 40, 3, 10, 1'b0, -1, 1'b0);
    endtask

    task automatic t_chain();
        do_start();
        stream("chain blk0", 40, 3, 10, 1'b1, -1, 1'b0);
        chk("R8 chain valid", valid_o, 1);
        stream("chain blk1 R8", 40, 3, 10, 1'b0, -1, 1'b0);
        chk("R8 idle after chain", valid_o, 0);
    endtask

    task automatic t_large();
        do_load(6144, 263, 480);
        do_start();
        stream("large", 6144, 263, 480, 1'b0, 4000, 1'b0);
    endtask

    task automatic t_unit();
        do_load(1, 0, 0);
        do_start();
        for (int j = 0; j < 3; j++) begin
            chk("R9 addr", addr_o, 0);
            chk("R9 first", first_o, 1);
            chk("R9 last", last_o, 1);
            ready = 1'b1;
            start = (j < 2);
            @(negedge clk);
            start = 1'b0;
        end
        chk("R9 idle", valid_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_stall_load();
        t_chain();
        t_large();
        t_unit();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule